// File: doc/BRIEF.md
# Instruction stream detector and collector

This block watches the program counter of a processor, one address per retired instruction, and cuts the trace into streams. A stream is a run of instructions fetched from consecutive word addresses with no taken branch inside it. Each time a stream closes, the block forms a record of its start address and its instruction count. The record goes into a small FIFO so that bursts of short streams are absorbed. Records are then looked up one at a time in a hashed stream table, so every distinct stream is reported with a stable identifier and streams seen for the first time are flagged.

Two enumerated state machines do the work. The detector has the states DET_EMPTY and DET_OPEN. The first valid PC moves it from DET_EMPTY to DET_OPEN. After that it stays in DET_OPEN, closing and reopening a stream whenever a PC breaks the sequence or the length cap is reached. The table engine has the states TBL_IDLE and TBL_LOOK. In TBL_IDLE it pops a waiting record and computes its index, then moves to TBL_LOOK. TBL_LOOK compares the stored entry, writes it on a miss, drives a one-cycle report and returns to TBL_IDLE. The PC input is never stalled. A record that arrives while the FIFO is full is discarded and a sticky overflow flag is raised.

The table stores only part of the start address (a tag) and the length. Two streams that share an index and a tag are therefore treated as the same stream. A stream that is still open is not reported until a later PC closes it.

Top module: `stream_tracker`

## Requirements
- R1: After reset, id_valid, new_stream and overflow are 0 and every table entry is invalid, so the first lookup of any stream reports new_stream = 1.
- R2: While pc_valid is 1, a PC that is not equal to the previous valid PC plus 4 closes the open stream. The reported record holds that stream's first PC and the number of PCs in it, and the incoming PC becomes the first PC of the next stream.
- R3: A stream holds at most MAX_LEN instructions. When a sequential PC arrives at a stream of MAX_LEN, that stream is reported with length MAX_LEN and the PC starts a new stream. Every reported length lies in 1..MAX_LEN.
- R4: Cycles with pc_valid = 0 have no effect on stream detection, whatever value pc carries in them.
- R5: Each closed stream produces exactly one report. A report is a single-cycle id_valid pulse carrying id, start_pc and length, and reports come in the order the streams closed. The id equals start_pc[IDX_W+1:2] XOR length (length zero-extended to IDX_W bits).
- R6: If the entry at the index is not valid, or its stored tag start_pc[TAG_W+1:2] or its stored length differs from the record, the report has new_stream = 1 and the entry is written with the record's tag and length and marked valid.
- R7: If the entry at the index is valid and both the tag and the length match, the report has new_stream = 0 and the entry is left unchanged.
- R8: A different stream that maps to an occupied index replaces the entry there, so the displaced stream is reported with new_stream = 1 the next time it occurs.
- R9: The FIFO holds FIFO_DEPTH records. A record arriving while the FIFO is full is discarded and overflow becomes 1, staying 1 until reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pc_valid | input | 1 | pc carries a retired instruction address this cycle |
| pc | input | PC_W | Retired instruction address |
| id | output | IDX_W | Stream identifier (table index) |
| id_valid | output | 1 | One-cycle report strobe |
| new_stream | output | 1 | Reported stream was not in the table |
| start_pc | output | PC_W | First address of the reported stream |
| length | output | LEN_W | Instruction count of the reported stream |
| overflow | output | 1 | Sticky flag: a record was dropped because the FIFO was full |

## Verification
The checker assumes that reports come no faster than one every two cycles, that each reported length lies between one and the cap, and that the identifier is formed from the reported address and length. These all follow from the block's own structure, so the checker needs no input assumption beyond a reset asserted from time zero. The bench compares reports against an exact arithmetic model. That comparison is only meaningful while no record is dropped, so every stimulus phase before the final burst keeps the FIFO from filling: it uses streams of two or more instructions, or inserts idle cycles between single-instruction streams. Only the last phase deliberately sends one branch per cycle to force the overflow, and there the per-report comparison is switched off.

// File: rtl/stream_pkg.sv
package stream_pkg;
    localparam int unsigned INSTR_BYTES = 4;

    typedef enum logic {
        DET_EMPTY,
        DET_OPEN
    } det_state_e;

    typedef enum logic {
        TBL_IDLE,
        TBL_LOOK
    } tbl_state_e;
endpackage

// File: rtl/stream_detector.sv
module stream_detector
    import stream_pkg::*;
#(
    parameter int unsigned PC_W    = 32,
    parameter int unsigned MAX_LEN = 12,
    parameter int unsigned LEN_W   = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pc_valid,
    input  logic [PC_W-1:0]  pc,
    output logic             rec_valid,
    output logic [PC_W-1:0]  rec_pc,
    output logic [LEN_W-1:0] rec_len
);
    det_state_e       state_q, state_d;
    logic [PC_W-1:0]  start_q;
    logic [PC_W-1:0]  last_q;
    logic [LEN_W-1:0] run_len_q;
    logic             sequential;
    logic             extend;

    always_comb begin
        sequential = (pc == last_q + PC_W'(INSTR_BYTES));
        extend     = (state_q == DET_OPEN) && sequential
                     && (run_len_q < LEN_W'(MAX_LEN));
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            DET_EMPTY: if (pc_valid) state_d = DET_OPEN;
            DET_OPEN:  state_d = DET_OPEN;
            default:   state_d = DET_EMPTY;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= DET_EMPTY;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rec_valid <= 1'b0;
            rec_pc    <= '0;
            rec_len   <= '0;
            start_q   <= '0;
            last_q    <= '0;
            run_len_q <= '0;
        end else begin
            rec_valid <= 1'b0;
            if (pc_valid) begin
                last_q <= pc;
                if (extend) begin
                    run_len_q <= run_len_q + LEN_W'(1);
                end else begin
                    if (state_q == DET_OPEN) begin
                        rec_valid <= 1'b1;
                        rec_pc    <= start_q;
                        rec_len   <= run_len_q;
                    end
                    start_q   <= pc;
                    run_len_q <= LEN_W'(1);
                end
            end
        end
    end
endmodule

// File: rtl/stream_fifo.sv
module stream_fifo #(
    parameter int unsigned DW    = 36,
    parameter int unsigned DEPTH = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [DW-1:0] din,
    input  logic          pop,
    output logic [DW-1:0] dout,
    output logic          empty,
    output logic          overflow
);
    localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int unsigned CW = $clog2(DEPTH + 1);

    logic [DW-1:0] mem [DEPTH];
    logic [AW-1:0] wr_ptr, rd_ptr;
    logic [CW-1:0] count;
    logic          full, do_push, do_pop;

    always_comb begin
        full    = (count == CW'(DEPTH));
        empty   = (count == '0);
        do_push = push && !full;
        do_pop  = pop && !empty;
        dout    = mem[rd_ptr];
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[wr_ptr] <= din;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr   <= '0;
            rd_ptr   <= '0;
            count    <= '0;
            overflow <= 1'b0;
        end else begin
            if (push && full) overflow <= 1'b1;
            if (do_push) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + AW'(1);
            if (do_pop)  rd_ptr <= (rd_ptr == AW'(DEPTH - 1)) ? '0 : rd_ptr + AW'(1);
            unique case ({do_push, do_pop})
                2'b10:   count <= count + CW'(1);
                2'b01:   count <= count - CW'(1);
                default: count <= count;
            endcase
        end
    end
endmodule

// File: rtl/stream_table.sv
module stream_table
    import stream_pkg::*;
#(
    parameter int unsigned PC_W  = 32,
    parameter int unsigned LEN_W = 4,
    parameter int unsigned IDX_W = 8,
    parameter int unsigned TAG_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rec_avail,
    input  logic [PC_W-1:0]  rec_pc,
    input  logic [LEN_W-1:0] rec_len,
    output logic             pop,
    output logic [IDX_W-1:0] id,
    output logic             id_valid,
    output logic             new_stream,
    output logic [PC_W-1:0]  start_pc,
    output logic [LEN_W-1:0] length
);
    localparam int unsigned ENTRIES = 1 << IDX_W;

    tbl_state_e       state_q, state_d;
    logic [TAG_W-1:0] tag_mem [ENTRIES];
    logic [LEN_W-1:0] len_mem [ENTRIES];
    logic [ENTRIES-1:0] valid_q;
    logic [PC_W-1:0]  cur_pc;
    logic [LEN_W-1:0] cur_len;
    logic [IDX_W-1:0] cur_idx;
    logic [IDX_W-1:0] hash_idx;
    logic [TAG_W-1:0] cur_tag;
    logic             hit;
    logic             write_en;

    always_comb begin
        hash_idx = rec_pc[2 +: IDX_W] ^ IDX_W'(rec_len);
        cur_tag  = cur_pc[2 +: TAG_W];
        hit      = valid_q[cur_idx] && (tag_mem[cur_idx] == cur_tag)
                   && (len_mem[cur_idx] == cur_len);
        pop      = (state_q == TBL_IDLE) && rec_avail;
        write_en = (state_q == TBL_LOOK) && !hit;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TBL_IDLE: if (rec_avail) state_d = TBL_LOOK;
            TBL_LOOK: state_d = TBL_IDLE;
            default:  state_d = TBL_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= TBL_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (write_en) begin
            tag_mem[cur_idx] <= cur_tag;
            len_mem[cur_idx] <= cur_len;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q    <= '0;
            cur_pc     <= '0;
            cur_len    <= '0;
            cur_idx    <= '0;
            id         <= '0;
            id_valid   <= 1'b0;
            new_stream <= 1'b0;
            start_pc   <= '0;
            length     <= '0;
        end else begin
            id_valid   <= 1'b0;
            new_stream <= 1'b0;
            if (pop) begin
                cur_pc  <= rec_pc;
                cur_len <= rec_len;
                cur_idx <= hash_idx;
            end
            if (state_q == TBL_LOOK) begin
                id_valid   <= 1'b1;
                new_stream <= !hit;
                id         <= cur_idx;
                start_pc   <= cur_pc;
                length     <= cur_len;
                if (write_en) valid_q[cur_idx] <= 1'b1;
            end
        end
    end
endmodule

// File: rtl/stream_tracker.sv
module stream_tracker #(
    parameter int unsigned PC_W       = 32,
    parameter int unsigned MAX_LEN    = 12,
    parameter int unsigned LEN_W      = $clog2(MAX_LEN + 1),
    parameter int unsigned IDX_W      = 8,
    parameter int unsigned TAG_W      = 12,
    parameter int unsigned FIFO_DEPTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pc_valid,
    input  logic [PC_W-1:0]  pc,
    output logic [IDX_W-1:0] id,
    output logic             id_valid,
    output logic             new_stream,
    output logic [PC_W-1:0]  start_pc,
    output logic [LEN_W-1:0] length,
    output logic             overflow
);
    localparam int unsigned REC_W = PC_W + LEN_W;

    logic             det_valid;
    logic [PC_W-1:0]  det_pc;
    logic [LEN_W-1:0] det_len;
    logic [REC_W-1:0] fifo_out;
    logic             fifo_empty;
    logic             tbl_pop;

    stream_detector #(
        .PC_W(PC_W), .MAX_LEN(MAX_LEN), .LEN_W(LEN_W)
    ) i_detector (
        .clk(clk), .rst_n(rst_n), .pc_valid(pc_valid), .pc(pc),
        .rec_valid(det_valid), .rec_pc(det_pc), .rec_len(det_len)
    );

    stream_fifo #(
        .DW(REC_W), .DEPTH(FIFO_DEPTH)
    ) i_fifo (
        .clk(clk), .rst_n(rst_n), .push(det_valid), .din({det_pc, det_len}),
        .pop(tbl_pop), .dout(fifo_out), .empty(fifo_empty), .overflow(overflow)
    );

    stream_table #(
        .PC_W(PC_W), .LEN_W(LEN_W), .IDX_W(IDX_W), .TAG_W(TAG_W)
    ) i_table (
        .clk(clk), .rst_n(rst_n), .rec_avail(!fifo_empty),
        .rec_pc(fifo_out[REC_W-1:LEN_W]), .rec_len(fifo_out[LEN_W-1:0]),
        .pop(tbl_pop), .id(id), .id_valid(id_valid), .new_stream(new_stream),
        .start_pc(start_pc), .length(length)
    );
endmodule

// File: rtl/stream_tracker_chk.sv
module stream_tracker_chk #(
    parameter int unsigned PC_W    = 32,
    parameter int unsigned MAX_LEN = 12,
    parameter int unsigned LEN_W   = 4,
    parameter int unsigned IDX_W   = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [IDX_W-1:0] id,
    input logic             id_valid,
    input logic             new_stream,
    input logic [PC_W-1:0]  start_pc,
    input logic [LEN_W-1:0] length,
    input logic             overflow
);
    a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        id_valid |=> !id_valid);

    a_r6_new_with_report: assert property (@(posedge clk) disable iff (!rst_n)
        new_stream |-> id_valid);

    a_r9_overflow_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        overflow |=> overflow);

    a_r3_length_bounds: assert property (@(posedge clk) disable iff (!rst_n)
        id_valid |-> (length != '0 && length <= LEN_W'(MAX_LEN)));

    a_r5_id_from_record: assert property (@(posedge clk) disable iff (!rst_n)
        id_valid |-> (id == (start_pc[2 +: IDX_W] ^ IDX_W'(length))));
endmodule

bind stream_tracker stream_tracker_chk #(
    .PC_W(PC_W), .MAX_LEN(MAX_LEN), .LEN_W(LEN_W), .IDX_W(IDX_W)
) i_stream_tracker_chk (
    .clk(clk), .rst_n(rst_n), .id(id), .id_valid(id_valid),
    .new_stream(new_stream), .start_pc(start_pc), .length(length),
    .overflow(overflow)
);

// File: tb/test_stream_tracker.sv
module test_stream_tracker;
    localparam int PC_W = 32;
    localparam int MAX_LEN = 12;
    localparam int LEN_W = 4;
    localparam int IDX_W = 8;
    localparam int TAG_W = 12;
    localparam int ENTRIES = 1 << IDX_W;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic             rst_n = 1'b0;
    logic             pc_valid = 1'b0;
    logic [PC_W-1:0]  pc = '0;
    logic [IDX_W-1:0] id;
    logic             id_valid, new_stream, overflow;
    logic [PC_W-1:0]  start_pc;
    logic [LEN_W-1:0] length;

    stream_tracker #(
        .PC_W(PC_W), .MAX_LEN(MAX_LEN), .LEN_W(LEN_W), .IDX_W(IDX_W),
        .TAG_W(TAG_W), .FIFO_DEPTH(8)
    ) i_stream_tracker (
        .clk(clk), .rst_n(rst_n), .pc_valid(pc_valid), .pc(pc), .id(id),
        .id_valid(id_valid), .new_stream(new_stream), .start_pc(start_pc),
        .length(length), .overflow(overflow)
    );

    int tests = 0;
    int fails = 0;
    bit done = 0;
    bit check_en = 1;
    int cap_seen = 0;
    int replaced_seen = 0;
    int hits_seen = 0;

    logic [PC_W-1:0] exp_pc [$];
    int              exp_len [$];

    bit              m_open = 0;
    logic [PC_W-1:0] m_start, m_last;
    int              m_len = 0;

    bit              t_valid [ENTRIES];
    int              t_tag [ENTRIES];
    int              t_len [ENTRIES];

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic send(input logic [PC_W-1:0] a);
        @(negedge clk);
        pc = a;
        pc_valid = 1'b1;
        if (m_open && a == m_last + 4 && m_len < MAX_LEN) begin
            m_len++;
        end else begin
            if (m_open) begin
                exp_pc.push_back(m_start);
                exp_len.push_back(m_len);
            end
            m_start = a;
            m_len = 1;
            m_open = 1;
        end
        m_last = a;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            pc_valid = 1'b0;
            pc = 32'hDEAD_BEE0 + PC_W'(i * 4);
        end
    endtask

    task automatic run_stream(input logic [PC_W-1:0] base, input int n);
        for (int k = 0; k < n; k++) send(base + PC_W'(4 * k));
        idle(1);
    endtask

    always @(negedge clk) begin
        if (rst_n && check_en && id_valid) begin
            if (exp_pc.size() == 0) begin
                check(0, "R5", "unexpected report", longint'(start_pc), 0);
            end else begin
                logic [PC_W-1:0] s;
                int l, idx, tg;
                bit hit;
                s = exp_pc.pop_front();
                l = exp_len.pop_front();
                idx = int'((s >> 2) & (ENTRIES - 1)) ^ l;
                tg = int'((s >> 2) & ((1 << TAG_W) - 1));
                hit = t_valid[idx] && t_tag[idx] == tg && t_len[idx] == l;
                check(start_pc == s, "R2", "start address", longint'(start_pc), longint'(s));
                check(int'(length) == l, "R2", "length", longint'(length), longint'(l));
                check(int'(id) == idx, "R5", "id", longint'(id), longint'(idx));
                if (hit) begin
                    hits_seen++;
                    check(new_stream == 1'b0, "R7", "new_stream on hit", longint'(new_stream), 0);
                end else begin
                    if (t_valid[idx]) replaced_seen++;
                    check(new_stream == 1'b1, "R6", "new_stream on miss", longint'(new_stream), 1);
                    t_valid[idx] = 1;
                    t_tag[idx] = tg;
                    t_len[idx] = l;
                end
                if (l == MAX_LEN) cap_seen++;
            end
        end
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual running expected finished");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < ENTRIES; i++) t_valid[i] = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: outputs quiet after reset
        check(id_valid == 1'b0, "R1", "id_valid after reset", longint'(id_valid), 0);
        check(new_stream == 1'b0, "R1", "new_stream after reset", longint'(new_stream), 0);
        check(overflow == 1'b0, "R1", "overflow after reset", longint'(overflow), 0);

        // R2, R3: sweep every length including ones above the cap, twice
        for (int pass = 0; pass < 2; pass++) begin
            for (int L = 1; L <= MAX_LEN + 3; L++)
                run_stream(32'h0001_0000 + PC_W'(L * 32'h200), L);
        end

        // R4: idle cycles with junk on pc inside a stream
        send(32'h0000_4000);
        idle(3);
        send(32'h0000_4004);
        idle(2);
        send(32'h0000_4008);
        idle(1);

        // R8: same index and length, different tag, then the first again
        run_stream(32'h0000_2000, 2);
        run_stream(32'h0000_2400, 2);
        run_stream(32'h0000_2000, 2);

        // R7: a loop body repeated with a backward branch
        for (int it = 0; it < 5; it++) begin
            for (int k = 0; k < 8; k++) send(32'h0000_3000 + PC_W'(4 * k));
        end
        send(32'h0000_9000);
        idle(30);

        // R5: every closed stream was reported in order
        check(exp_pc.size() == 0, "R5", "records left unreported",
              longint'(exp_pc.size()), 0);
        check(cap_seen > 0, "R3", "records at the length cap", longint'(cap_seen), 1);
        check(replaced_seen > 0, "R8", "replaced entries reported new",
              longint'(replaced_seen), 1);
        check(hits_seen > 0, "R7", "repeat streams hitting", longint'(hits_seen), 1);
        check(overflow == 1'b0, "R9", "overflow before burst", longint'(overflow), 0);

        // R9: one branch per cycle outruns the table
        check_en = 0;
        for (int i = 0; i < 40; i++) send(32'h0008_0000 + PC_W'(i * 64));
        idle(4);
        check(overflow == 1'b1, "R9", "overflow after burst", longint'(overflow), 1);
        idle(100);
        check(overflow == 1'b1, "R9", "overflow sticky", longint'(overflow), 1);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule